// File: doc/BRIEF.md
# Shuffling Decorrelator for Unipolar Bit-Streams

This block moves the 1s of a serial stochastic bit-stream to new positions without changing how many there are. Moving them this way weakens both the correlation between the stream and other streams that share its random source and the correlation of the stream with delayed copies of itself. A small bank of DEPTH one-bit slots holds recent input bits. On every valid input bit, a free-running LFSR picks one of DEPTH+1 candidates: the DEPTH stored bits, or the bit arriving now. The picked bit leaves on the output. The arriving bit takes the vacated slot, or passes straight through when it was the one picked.

After a clear, the first DEPTH valid bits only fill the slots, and nothing is emitted. Once the slots are full, every valid input bit produces exactly one output bit on the following cycle. At the end of a stream, the drain input empties the slots one bit per cycle while no input is offered. The output stream therefore carries exactly as many 1s as the input stream did. When DEPTH+1 is not a power of two, the index is taken from the first in-range field of the LFSR word. If every field is out of range, a wrapped value is used instead, which leaves a small bias towards the low indices.

Top module: `bit_shuffler`

## Requirements
- R1: After reset, and on the cycle after `clear` is high, `dout_vld` is 0 and all slots count as empty. `clear` takes priority over every other input.
- R2: While fewer than DEPTH slots are occupied, a valid input bit (`din_vld`=1) is stored, and `dout_vld` is 0 on the following cycle.
- R3: With all DEPTH slots occupied, every valid input bit produces `dout_vld`=1 on the following cycle, and the slots stay full.
- R4: Every emitted bit is either a bit held in a slot or the bit arriving in that same cycle, and each held bit is emitted at most once. Over a stream that is filled, run and then drained, the number of 1s on `dout` equals the number of 1s accepted on `din`.
- R5: In a cycle with `din_vld`=0 and `drain`=0, and also in a cycle with `drain`=1 while the slots are empty, `dout_vld` is 0 on the next cycle and the slot occupancy does not change.
- R6: With `din_vld`=0 and `drain`=1, one held bit is emitted per cycle (`dout_vld`=1 on the next cycle) and the occupancy drops by one, until the slots are empty.
- R7: The selection index always lies in 0..DEPTH. With all slots holding 0 and a 1 arriving, the output is 1 only when the arriving bit is picked. This happens in roughly 1/(DEPTH+1) of the trials, so neither the pass-through choice nor the stored choices are starved.
- R8: When `din_vld` and `drain` are both 1, the input is handled as an ordinary valid bit and the drain request has no effect for that cycle.
- R9: After a complete drain, the block fills again: the next DEPTH valid bits produce no output, and the bit after them produces one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart; empties all slots, active high |
| din | input | 1 | Incoming stream bit |
| din_vld | input | 1 | `din` carries a bit this cycle, active high |
| drain | input | 1 | Emit one held bit per cycle while no input is offered, active high |
| dout | output | 1 | Outgoing stream bit, registered |
| dout_vld | output | 1 | `dout` carries a bit this cycle, active high |

## Verification
The hardest case to reach from the ports is the one where the LFSR picks the arriving bit. In steady operation this choice cannot be told apart from a swap, because the output is just another bit of the same value. The stimulus therefore clears the block, fills every slot with 0 and then offers a single 1. Only a pass-through can put a 1 on the output, so repeating this trial a few hundred times measures how often the top index is chosen. A reference that tracks the number of held 1s and 0s checks every emitted bit against what could legally be present. This reference runs over random, all-ones, sparse and alternating streams of lengths around DEPTH, and it covers drains interrupted by input, drains of an empty bank, and partial fills.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

   // width of an index that can name DEPTH slots plus the arriving bit
   function automatic int unsigned sel_bits(input int unsigned depth);
      return (depth < 1) ? 1 : $clog2(depth + 1);
   endfunction

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FILL  = 2'd1,
      OP_SWAP  = 2'd2,
      OP_DRAIN = 2'd3
   } shuf_op_e;

endpackage

// File: rtl/shuf_lfsr.sv
module shuf_lfsr #(
   parameter int unsigned       W    = 16,
   parameter int unsigned       OW   = 15,
   parameter logic [W-1:0]      TAPS = 16'hB400,
   parameter logic [W-1:0]      SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [OW-1:0] bits
);

   if (W < 2)      begin : g_bad_w    $error("shuf_lfsr: W must be at least 2");   end
   if (OW > W)     begin : g_bad_ow   $error("shuf_lfsr: OW must not exceed W");   end
   if (SEED == '0) begin : g_bad_seed $error("shuf_lfsr: SEED must be non-zero"); end

   logic [W-1:0] state_q;
   logic         feed;

   assign feed = ^(state_q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= {state_q[W-2:0], feed};
   end

   assign bits = state_q[OW-1:0];

endmodule

// File: rtl/shuf_pick.sv
module shuf_pick #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IW    = 3,
   parameter int unsigned NTRY  = 5
) (
   input  logic [NTRY*IW-1:0] rnd,
   output logic [IW-1:0]      idx
);

   localparam int unsigned SPAN = DEPTH + 1;

   if (NTRY < 1) begin : g_bad_ntry $error("shuf_pick: need at least one field"); end

   if (SPAN == (1 << IW)) begin : g_direct
      // every field value is legal: fold all fields together
      always_comb begin
         idx = '0;
         for (int k = 0; k < NTRY; k++) idx = idx ^ rnd[k*IW +: IW];
      end
   end else begin : g_redraw
      localparam logic [IW-1:0] TOP  = IW'(DEPTH);
      localparam logic [IW-1:0] WRAP = IW'(SPAN);
      logic [IW-1:0] fallback;

      // out-of-range value folded back; only used when all fields miss
      assign fallback = rnd[IW-1:0] - WRAP;

      always_comb begin
         idx = fallback;
         for (int k = NTRY - 1; k >= 0; k--) begin
            if (rnd[k*IW +: IW] <= TOP) idx = rnd[k*IW +: IW];
         end
      end
   end

endmodule

// File: rtl/shuf_slots.sv
module shuf_slots #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IW-1:0]    waddr,
   input  logic             wbit,
   output logic [DEPTH-1:0] bits
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= 1'b0;
         else if (we && (waddr == IW'(g)))    q <= wbit;
      end
      assign bits[g] = q;
   end

endmodule

// File: rtl/bit_shuffler.sv
module bit_shuffler
   import shuf_pkg::*;
#(
   parameter int unsigned          DEPTH     = 4,
   parameter int unsigned          LFSR_W    = 16,
   parameter logic [LFSR_W-1:0]    LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0]    LFSR_SEED = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic din,
   input  logic din_vld,
   input  logic drain,
   output logic dout,
   output logic dout_vld
);

   localparam int unsigned     IW   = sel_bits(DEPTH);
   localparam int unsigned     NTRY = LFSR_W / IW;
   localparam int unsigned     PW   = NTRY * IW;
   localparam logic [IW-1:0]   FULL = IW'(DEPTH);

   if (DEPTH < 1)     begin : g_bad_depth $error("bit_shuffler: DEPTH must be at least 1"); end
   if (LFSR_W < IW)   begin : g_bad_lfsr  $error("bit_shuffler: LFSR_W narrower than index"); end

   logic [PW-1:0]    rnd;
   logic [IW-1:0]    pick_idx;
   logic [DEPTH-1:0] slot_bits;
   logic [IW-1:0]    fill_q, fill_d;
   logic             we;
   logic [IW-1:0]    waddr;
   logic             sel_bit, top_bit;
   logic             nxt_out, nxt_vld;
   shuf_op_e         op;

   shuf_lfsr #(
      .W    (LFSR_W),
      .OW   (PW),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .bits  (rnd)
   );

   shuf_pick #(
      .DEPTH (DEPTH),
      .IW    (IW),
      .NTRY  (NTRY)
   ) u_pick (
      .rnd (rnd),
      .idx (pick_idx)
   );

   shuf_slots #(
      .DEPTH (DEPTH),
      .IW    (IW)
   ) u_slots (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wbit  (din),
      .bits  (slot_bits)
   );

   // read muxes: randomly indexed slot, and highest occupied slot
   always_comb begin
      sel_bit = 1'b0;
      top_bit = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (pick_idx == IW'(k))   sel_bit = slot_bits[k];
         if (fill_q == IW'(k + 1)) top_bit = slot_bits[k];
      end
   end

   // operation of this cycle; clear overrides, input beats drain
   always_comb begin
      if (clear)                         op = OP_IDLE;
      else if (din_vld && fill_q != FULL) op = OP_FILL;
      else if (din_vld)                  op = OP_SWAP;
      else if (drain && fill_q != '0)    op = OP_DRAIN;
      else                               op = OP_IDLE;
   end

   always_comb begin
      we      = 1'b0;
      waddr   = fill_q;
      fill_d  = fill_q;
      nxt_out = 1'b0;
      nxt_vld = 1'b0;
      unique case (op)
         OP_FILL: begin
            we     = 1'b1;
            fill_d = fill_q + 1'b1;
         end
         OP_SWAP: begin
            nxt_vld = 1'b1;
            if (pick_idx == FULL) begin
               nxt_out = din;
            end else begin
               nxt_out = sel_bit;
               we      = 1'b1;
               waddr   = pick_idx;
            end
         end
         OP_DRAIN: begin
            nxt_vld = 1'b1;
            nxt_out = top_bit;
            fill_d  = fill_q - 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q   <= '0;
         dout     <= 1'b0;
         dout_vld <= 1'b0;
      end else if (clear) begin
         fill_q   <= '0;
         dout     <= 1'b0;
         dout_vld <= 1'b0;
      end else begin
         fill_q   <= fill_d;
         dout     <= nxt_out;
         dout_vld <= nxt_vld;
      end
   end

endmodule

// File: rtl/shuf_chk.sv
module shuf_chk #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clear,
   input logic          din_vld,
   input logic          drain,
   input logic          dout_vld,
   input logic [IW-1:0] fill,
   input logic [IW-1:0] idx
);

   localparam logic [IW-1:0] FULL = IW'(DEPTH);

   a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!dout_vld && fill == '0));

   a_r2_silent_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && din_vld && fill < FULL) |=> (!dout_vld && fill == $past(fill) + 1'b1));

   a_r3_full_emits: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && din_vld && fill == FULL) |=> (dout_vld && fill == FULL));

   a_r3_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL);

   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !din_vld && (!drain || fill == '0)) |=> (!dout_vld && $stable(fill)));

   a_r6_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !din_vld && drain && fill != '0) |=> (dout_vld && fill == $past(fill) - 1'b1));

   a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= FULL);

endmodule

bind bit_shuffler shuf_chk #(
   .DEPTH (DEPTH),
   .IW    (IW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .din_vld  (din_vld),
   .drain    (drain),
   .dout_vld (dout_vld),
   .fill     (fill_q),
   .idx      (pick_idx)
);

// File: tb/bit_shuffler_test.sv
module bit_shuffler_test;

   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0;
   logic din = 1'b0;
   logic din_vld = 1'b0;
   logic drain = 1'b0;
   logic dout, dout_vld;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   // reference model: occupancy, held ones, stream totals
   int held = 0;
   int held_ones = 0;
   int in_ones = 0;
   int out_ones = 0;

   always #4 clk = ~clk;   // 125 MHz

   bit_shuffler #(.DEPTH(DEPTH)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .din      (din),
      .din_vld  (din_vld),
      .drain    (drain),
      .dout     (dout),
      .dout_vld (dout_vld)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // drive one cycle at the negative edge, check at the next negative edge
   task automatic step(input bit v, input bit b, input bit dr, input bit cl);
      din_vld = v; din = b; drain = dr; clear = cl;
      @(negedge clk);
      if (cl) begin
         chk(dout_vld == 1'b0, "R1 clear leaves output invalid", int'(dout_vld), 0);
         held = 0; held_ones = 0; in_ones = 0; out_ones = 0;
      end else if (v && held < DEPTH) begin
         chk(dout_vld == 1'b0, "R2 no output while filling", int'(dout_vld), 0);
         held++; held_ones += int'(b); in_ones += int'(b);
      end else if (v) begin
         chk(dout_vld == 1'b1, "R3 full bank emits per input", int'(dout_vld), 1);
         if (dout) chk(held_ones + int'(b) >= 1, "R4 emitted 1 not available", held_ones + int'(b), 1);
         else      chk(held - held_ones + 1 - int'(b) >= 1, "R4 emitted 0 not available",
                       held - held_ones + 1 - int'(b), 1);
         in_ones += int'(b);
         held_ones = held_ones + int'(b) - int'(dout);
         out_ones += int'(dout);
      end else if (dr && held > 0) begin
         chk(dout_vld == 1'b1, "R6 drain emits one bit", int'(dout_vld), 1);
         if (dout) chk(held_ones >= 1, "R6 drained 1 not held", held_ones, 1);
         else      chk(held - held_ones >= 1, "R6 drained 0 not held", held - held_ones, 1);
         held--; held_ones -= int'(dout); out_ones += int'(dout);
      end else begin
         chk(dout_vld == 1'b0, "R5 idle or empty drain is silent", int'(dout_vld), 0);
      end
      din_vld = 0; drain = 0; clear = 0;
   endtask

   // mode 0 random, 1 all ones, 2 alternating, 3 sparse
   task automatic run_stream(input int len, input int mode);
      step(0, 0, 0, 1);
      for (int i = 0; i < len; i++) begin
         bit b;
         case (mode)
            0: b = $urandom_range(1, 0) == 1;
            1: b = 1'b1;
            2: b = i[0];
            default: b = ($urandom_range(7, 0) == 0);
         endcase
         step(1, b, 0, 0);
         if ($urandom_range(9, 0) == 0) step(0, 0, 0, 0);
      end
      while (held > 0) step(0, 0, 1, 0);
      step(0, 0, 1, 0);   // drain on an empty bank
      chk(in_ones == out_ones, "R4 stream ones conserved", out_ones, in_ones);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int passes;
      repeat (3) @(negedge clk);
      chk(dout_vld == 1'b0, "R1 reset output invalid", int'(dout_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout_vld == 1'b0, "R1 output invalid after reset release", int'(dout_vld), 0);

      // streams of assorted lengths and patterns
      run_stream(1, 0);
      run_stream(DEPTH - 1, 1);
      run_stream(DEPTH, 0);
      run_stream(DEPTH + 1, 1);
      run_stream(37, 2);
      run_stream(120, 3);
      run_stream(200, 0);
      run_stream(64, 1);

      // R8: input beats drain; then full drain and R9 refill
      step(0, 0, 0, 1);
      for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0);
      step(1, 0, 1, 0);
      chk(held == DEPTH, "R8 drain ignored while input valid", held, DEPTH);
      for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0);
      chk(held == 0 && in_ones == out_ones, "R6 drain empties bank", held, 0);
      for (int i = 0; i < DEPTH; i++) step(1, i[0], 0, 0);
      step(1, 1, 0, 0);
      chk(held == DEPTH, "R9 refill after drain", held, DEPTH);
      step(1, 1, 1, 1);   // clear beats everything
      chk(held == 0, "R1 clear dominates", held, 0);

      // R7: pass-through rate with a zero-filled bank
      passes = 0;
      for (int t = 0; t < 300; t++) begin
         step(0, 0, 0, 1);
         for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0);
         step(1, 1, 0, 0);
         if (dout) passes++;
      end
      chk(passes >= 20 && passes <= 120, "R7 pass-through rate near 1/(DEPTH+1)", passes, 60);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule